// File: doc/BRIEF.md
# I2C Register Target with Strap-Selected Address

This block is an I2C target that lets a bus host write and read a bank of sixteen 8-bit registers. SCL and SDA arrive as plain inputs and pass through two-flop synchronizers. All bus events are then found in a system clock domain, which must run at least eight times faster than SCL. The block never drives SDA high. It only asserts an open-drain enable that pulls the line low.

The 7-bit target address is `10001` followed by two bits taken from one strap pin. The block decodes that pin continuously by comparing it with the synchronized bus lines. A pin that tracks SCL across several SCL transitions selects `01`. A pin that tracks SDA across several SDA transitions selects `10`. A pin that holds still selects `00` when low and `11` when high. The decoded pair is captured at every START, so four such targets can share one bus.

A host write sends the address with R/W = 0, then one pointer byte, then any number of data bytes. A host read first sets the pointer the same way, then issues a repeated START and the address with R/W = 1, and clocks data out. The pointer advances after every data byte, in both directions. The bus has no data stream that could apply back-pressure, and the block does not stretch the clock. All pins are plain control signals.

Top module: `i2cs_target`

## Requirements
- R1: The target acknowledges by pulling SDA low during the ninth SCL pulse only when the first 7 bits after START, sent MSB first, equal `10001` followed by the latched strap pair. The eighth bit selects write (0) or read (1).
- R2: For a non-matching address, the target leaves SDA released for the whole transfer.
- R3: The strap pair decodes as 00 when the pin is tied low and 11 when tied high. It decodes as 01 when the pin follows SCL for at least 4 SCL transitions, and as 10 when the pin follows SDA for at least 4 SDA transitions. The value is latched at each START.
- R4: In a write, the target acknowledges the pointer byte and every data byte, and stores each data byte (MSB first) at the current pointer.
- R5: The pointer increments by one after every data byte written or read, so bursts reach consecutive registers.
- R6: After a repeated START with R/W = 1, the target shifts out the register at the pointer, MSB first, one bit per SCL low phase.
- R7: After the host answers a read byte with NACK (SDA high on the ninth clock), the target keeps SDA released until the next START or STOP.
- R8: Writes to pointers 16 and above are acknowledged but change no register. Reads at pointers 16 and above return 0x00.
- R9: A STOP (SDA rising while SCL is high) returns the target to idle with SDA released. The target never drives SDA while idle.
- R10: After reset, SDA is released and all registers read 0x00.
- R11: The target changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (wired level) |
| strap_i | input | 1 | Address strap pin: tied low, high, to SCL or to SDA |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
The checker watches four properties on every cycle. SDA is released whenever the target is idle or waiting after a host NACK. Every change of the drive enable falls within an SCL low phase. A STOP always leaves the target idle. Any pointer past the bank reads as zero.

Other behaviours can only be shown by bench scenarios. These are address matching against each strap wiring, acknowledge counts, the data actually stored and returned across bursts, pointer increment over the bank's edge, and the quiet bus after a NACK. The bench sweeps all four strap wirings and, for each one, all four candidate address codes.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_PTR,
    ST_PTR_ACK,
    ST_WDAT,
    ST_WDAT_ACK,
    ST_RDAT,
    ST_RDAT_ACK,
    ST_WAIT
  } bus_st_e;

  localparam logic [4:0] ADDR_PREFIX = 5'b10001;
  localparam int BYTE_W = 8;
endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
  parameter int         W       = 1,
  parameter bit [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/i2cs_strap.sv
module i2cs_strap #(
  parameter int FOLLOW_EDGES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin,
  input  logic       scl,
  input  logic       sda,
  output logic [1:0] code
);
  localparam int CW = $clog2(FOLLOW_EDGES + 1);
  localparam logic [CW-1:0] CMAX = CW'(FOLLOW_EDGES);

  logic [1:0] line, line_q, locked;
  assign line = {sda, scl};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= 2'b11;
    else        line_q <= line;
  end

  // one follower counter per bus line: index 0 tracks SCL, index 1 tracks SDA
  for (genvar g = 0; g < 2; g++) begin : g_follow
    logic [CW-1:0] cnt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   cnt <= '0;
      else if (pin != line[g])                      cnt <= '0;
      else if (line[g] != line_q[g] && cnt != CMAX) cnt <= cnt + 1'b1;
    end
    assign locked[g] = (cnt == CMAX);
  end

  always_comb begin
    if (locked[0])      code = 2'b01;
    else if (locked[1]) code = 2'b10;
    else                code = {pin, pin};
  end
endmodule

// File: rtl/i2cs_regbank.sv
module i2cs_regbank #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_reg
    logic [DW-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          q <= '0;
      else if (we && waddr == AW'(g))      q <= wdata;
    end
    assign mem[g] = q;
  end

  assign rdata = (32'(raddr) < DEPTH) ? mem[raddr[IW-1:0]] : '0;
endmodule

// File: rtl/i2cs_target.sv
module i2cs_target
  import i2cs_pkg::*;
#(
  parameter int DEPTH        = 16,
  parameter int FOLLOW_EDGES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic strap_i,
  output logic sda_oe
);
  localparam int AW = BYTE_W;
  localparam logic [3:0] LAST_BIT = 4'd8;

  logic [2:0] sync_q;
  logic       scl_s, sda_s, strap_s, scl_p, sda_p;
  logic       scl_rise, scl_fall, start_ev, stop_ev;
  logic [1:0] strap_code, strap_lat;

  bus_st_e           st;
  logic [3:0]        bitcnt;
  logic [BYTE_W-1:0] shreg, rdata;
  logic [AW-1:0]     ptr;
  logic              rw, host_ack, we;

  i2cs_sync #(.W(3), .RST_VAL(3'b111)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({strap_i, sda_i, scl_i}), .q(sync_q)
  );
  assign {strap_s, sda_s, scl_s} = sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;
  assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;

  i2cs_strap #(.FOLLOW_EDGES(FOLLOW_EDGES)) u_strap (
    .clk(clk), .rst_n(rst_n), .pin(strap_s), .scl(scl_s), .sda(sda_s),
    .code(strap_code)
  );

  assign we = (st == ST_WDAT) && scl_fall && (bitcnt == LAST_BIT);

  i2cs_regbank #(.DEPTH(DEPTH), .DW(BYTE_W), .AW(AW)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(we), .waddr(ptr), .wdata(shreg),
    .raddr(ptr), .rdata(rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      bitcnt    <= '0;
      shreg     <= '0;
      ptr       <= '0;
      rw        <= 1'b0;
      host_ack  <= 1'b0;
      strap_lat <= '0;
      sda_oe    <= 1'b0;
    end else if (start_ev) begin
      st        <= ST_ADDR;
      bitcnt    <= '0;
      sda_oe    <= 1'b0;
      strap_lat <= strap_code;
    end else if (stop_ev) begin
      st     <= ST_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (st)
        ST_ADDR, ST_PTR, ST_WDAT: begin
          if (scl_rise) begin
            shreg  <= {shreg[BYTE_W-2:0], sda_s};
            bitcnt <= bitcnt + 1'b1;
          end else if (scl_fall && bitcnt == LAST_BIT) begin
            bitcnt <= '0;
            if (st == ST_ADDR) begin
              if (shreg[7:1] == {ADDR_PREFIX, strap_lat}) begin
                sda_oe <= 1'b1;
                rw     <= shreg[0];
                st     <= ST_ADDR_ACK;
              end else begin
                st <= ST_IDLE;
              end
            end else if (st == ST_PTR) begin
              ptr    <= shreg;
              sda_oe <= 1'b1;
              st     <= ST_PTR_ACK;
            end else begin
              ptr    <= ptr + 1'b1;
              sda_oe <= 1'b1;
              st     <= ST_WDAT_ACK;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            if (rw) begin
              shreg  <= rdata;
              sda_oe <= ~rdata[BYTE_W-1];
              st     <= ST_RDAT;
            end else begin
              sda_oe <= 1'b0;
              st     <= ST_PTR;
            end
          end
        end
        ST_PTR_ACK, ST_WDAT_ACK: begin
          if (scl_fall) begin
            sda_oe <= 1'b0;
            st     <= ST_WDAT;
          end
        end
        ST_RDAT: begin
          if (scl_rise) begin
            bitcnt <= bitcnt + 1'b1;
          end else if (scl_fall) begin
            if (bitcnt == LAST_BIT) begin
              sda_oe <= 1'b0;
              bitcnt <= '0;
              ptr    <= ptr + 1'b1;
              st     <= ST_RDAT_ACK;
            end else begin
              shreg  <= {shreg[BYTE_W-2:0], 1'b0};
              sda_oe <= ~shreg[BYTE_W-2];
            end
          end
        end
        ST_RDAT_ACK: begin
          if (scl_rise) begin
            host_ack <= ~sda_s;
          end else if (scl_fall) begin
            if (host_ack) begin
              shreg  <= rdata;
              sda_oe <= ~rdata[BYTE_W-1];
              st     <= ST_RDAT;
            end else begin
              st <= ST_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2cs_chk.sv
module i2cs_chk
  import i2cs_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_oe,
  input bus_st_e    st,
  input logic       stop_ev,
  input logic [7:0] rd_ptr,
  input logic [7:0] rd_data
);
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !sda_oe); // R9

  AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> (st == ST_IDLE && !sda_oe)); // R9

  AST_NACK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT) |-> !sda_oe); // R7

  AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_i); // R11

  AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(rd_ptr) >= DEPTH) |-> (rd_data == 8'h00)); // R8
endmodule

bind i2cs_target i2cs_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe), .st(st),
  .stop_ev(stop_ev), .rd_ptr(ptr), .rd_data(rdata)
);

// File: tb/tb_i2cs_target.sv
module tb_i2cs_target;
  localparam int CLK_NS = 10;
  localparam int Q      = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic host_sda = 1'b1;
  logic dut_oe;
  logic sda_line;
  logic strap;
  int   strap_sel = 0;
  int   n_tests = 0;
  int   n_fail = 0;
  int   oe_cnt = 0;
  int   bad_cnt = 0;
  logic oe_prev = 1'b0;
  logic [7:0] model [16];

  always #(CLK_NS / 2) clk = ~clk;

  assign sda_line = host_sda & ~dut_oe;
  assign strap = (strap_sel == 0) ? 1'b0 : (strap_sel == 1) ? 1'b1 :
                 (strap_sel == 2) ? scl : sda_line;

  i2cs_target dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .strap_i(strap), .sda_oe(dut_oe)
  );

  always @(posedge clk) begin
    if (dut_oe) oe_cnt <= oe_cnt + 1;
    if (dut_oe != oe_prev && scl) bad_cnt <= bad_cnt + 1;
    oe_prev <= dut_oe;
  end

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    host_sda = 1'b1; scl = 1'b1; wq(Q);
    host_sda = 1'b0; wq(Q);
    scl = 1'b0; wq(Q);
  endtask

  task automatic bus_restart();
    host_sda = 1'b1; wq(Q);
    scl = 1'b1; wq(Q);
    host_sda = 1'b0; wq(Q);
    scl = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    host_sda = 1'b0; wq(Q);
    scl = 1'b1; wq(Q);
    host_sda = 1'b1; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      host_sda = b[i]; wq(Q);
      scl = 1'b1; wq(2 * Q);
      scl = 1'b0; wq(Q);
    end
    host_sda = 1'b1; wq(Q);
    scl = 1'b1; wq(Q);
    acked = ~sda_line; wq(Q);
    scl = 1'b0; wq(Q);
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    host_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(Q);
      scl = 1'b1; wq(Q);
      b[i] = sda_line; wq(Q);
      scl = 1'b0;
    end
    wq(Q);
    host_sda = give_ack ? 1'b0 : 1'b1;
    scl = 1'b1; wq(2 * Q);
    scl = 1'b0; wq(Q);
    host_sda = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R9 actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    bit         ack;
    logic [7:0] rb;
    logic [1:0] exp_code;
    logic [7:0] aw, ar;
    int         base;
    int         p;

    for (int s = 0; s < 4; s++) begin
      strap_sel = s;
      // R3: gnd -> 00, supply -> 11, follows SCL -> 01, follows SDA -> 10
      exp_code = (s == 0) ? 2'b00 : (s == 1) ? 2'b11 : (s == 2) ? 2'b01 : 2'b10;
      aw = {5'b10001, exp_code, 1'b0};
      ar = {5'b10001, exp_code, 1'b1};
      for (int i = 0; i < 16; i++) model[i] = 8'h00;

      rst_n = 1'b0; host_sda = 1'b1; scl = 1'b1; wq(5);
      rst_n = 1'b1; wq(5);
      chk(dut_oe == 1'b0, "R10 reset release", dut_oe, 0);

      // warm-up transfer to another address: also lets the strap decoder lock
      base = oe_cnt;
      bus_start(); send_byte(8'h54, ack); bus_stop();
      chk(!ack, "R2 foreign address ack", ack, 0);
      chk(oe_cnt == base, "R2 foreign address drive", oe_cnt - base, 0);

      if (s == 0) begin
        bus_start(); send_byte(aw, ack); send_byte(8'h00, ack);
        bus_restart(); send_byte(ar, ack);
        for (int i = 0; i < 16; i++) begin
          recv_byte(i < 15, rb);
          chk(rb == 8'h00, "R10 register after reset", rb, 0);
        end
        bus_stop();
      end

      for (int c = 0; c < 4; c++) begin
        base = oe_cnt;
        bus_start(); send_byte({5'b10001, 2'(c), 1'b0}, ack); bus_stop();
        chk(ack == (2'(c) == exp_code), "R3 strap address match", ack, 2'(c) == exp_code);
        if (2'(c) != exp_code)
          chk(oe_cnt == base, "R2 mismatched code silent", oe_cnt - base, 0);
      end

      // burst write then repeated-START read
      p = s * 3 + 1;
      bus_start();
      send_byte(aw, ack); chk(ack, "R1 write address ack", ack, 1);
      send_byte(8'(p), ack); chk(ack, "R4 pointer ack", ack, 1);
      for (int k = 0; k < 3; k++) begin
        rb = 8'((s * 37 + k * 91 + 5) & 255);
        send_byte(rb, ack); chk(ack, "R4 data ack", ack, 1);
        model[p + k] = rb;
      end
      bus_stop();

      bus_start(); send_byte(aw, ack); send_byte(8'(p), ack);
      bus_restart();
      send_byte(ar, ack); chk(ack, "R6 read address ack", ack, 1);
      for (int k = 0; k < 3; k++) begin
        recv_byte(k < 2, rb);
        if (k == 0) chk(rb == model[p], "R6 read data", rb, model[p]);
        else        chk(rb == model[p + k], "R5 pointer increment", rb, model[p + k]);
      end
      base = oe_cnt;
      wq(2 * Q);
      scl = 1'b1; wq(Q);
      chk(sda_line == 1'b1, "R7 released after NACK", sda_line, 1);
      wq(Q); scl = 1'b0; wq(2 * Q);
      chk(oe_cnt == base, "R7 no drive after NACK", oe_cnt - base, 0);
      bus_stop();
      chk(dut_oe == 1'b0, "R9 released after STOP", dut_oe, 0);

      // writes crossing the end of the bank
      bus_start(); send_byte(aw, ack); send_byte(8'd14, ack);
      for (int k = 0; k < 3; k++) begin
        rb = 8'(8'hA0 + s * 16 + k);
        send_byte(rb, ack);
        chk(ack, "R8 write ack across bank end", ack, 1);
        if (14 + k < 16) model[14 + k] = rb;
      end
      bus_stop();
      bus_start(); send_byte(aw, ack); send_byte(8'h80, ack);
      chk(ack, "R8 far pointer ack", ack, 1);
      send_byte(8'h77, ack);
      chk(ack, "R8 far write ack", ack, 1);
      bus_stop();

      bus_start(); send_byte(aw, ack); send_byte(8'd14, ack);
      bus_restart(); send_byte(ar, ack);
      for (int k = 0; k < 4; k++) begin
        recv_byte(k < 3, rb);
        if (k < 2) chk(rb == model[14 + k], "R8 last registers", rb, model[14 + k]);
        else       chk(rb == 8'h00, "R8 read past bank", rb, 0);
      end
      bus_stop();

      bus_start(); send_byte(aw, ack); send_byte(8'h80, ack);
      bus_restart(); send_byte(ar, ack);
      recv_byte(1'b0, rb);
      bus_stop();
      chk(rb == 8'h00, "R8 ignored far write", rb, 0);

      chk(bad_cnt == 0, "R11 drive change while SCL high", bad_cnt, 0);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule